// File: doc/BRIEF.md
# Multi-Format Low-Precision Float Converter

This block narrows single-precision (FP32) operands into the compact floating-point encodings used by machine-learning datapaths, and widens such codes back to FP32. Four narrow encodings are supported: a 16-bit format with the full 8-bit FP32 exponent and a 7-bit fraction, an 8-bit format with a 4-bit exponent and a 3-bit fraction, an 8-bit format with a 5-bit exponent and a 2-bit fraction, and a 4-bit format with a 2-bit exponent and a 1-bit fraction. A 3-bit mode input, sampled with each operand, picks the target encoding and the direction.

When narrowing, the block re-biases the exponent and rounds the fraction to nearest with ties to even. Values too small for a normal result become subnormal codes or signed zero. Overflow, infinities and NaNs are handled by rules that depend on the target encoding. Operands enter through a valid/ready handshake. The result leaves through a second handshake exactly two accepting clock edges later. The pipeline accepts one operand per cycle for as long as the consumer keeps taking results.

Top module: `lpf_convert`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R2: An operand accepted on a clock edge, with the output never stalled, appears on `out_data` with `out_valid` high after the second following edge. Results keep input order, and the block takes one operand per cycle.
- R3: Mode codes are as follows. 0 narrows to the 16-bit format, 1 to the 8-bit 4/3 format, 2 to the 8-bit 5/2 format and 3 to the 4-bit format. Modes 4 to 7 widen from those same formats in the same order. A narrow result sits in the low bits of `out_data`, with its sign in the format's top bit (bit 15, 7, 7 or 3), and every higher output bit is zero.
- R4: Narrowing rounds the dropped fraction bits to nearest. An exact tie picks the candidate whose last kept bit is 0.
- R5: 8-bit 4/3 format (exponent bias 7): a finite overflow or an infinity gives the signed largest finite code, 0x7E or 0xFE (magnitude 448). A NaN input gives 0x7F. No other input produces 0x7F or 0xFF.
- R6: 8-bit 5/2 format (exponent bias 15): an overflow or an infinity gives signed infinity, 0x7C or 0xFC. A NaN input gives 0x7E.
- R7: 4-bit format (exponent bias 1, largest magnitude 6.0): an overflow or an infinity gives 0x7 or 0xF. A NaN input gives 0x7.
- R8: 16-bit format (exponent bias 127): the result is the upper half of the FP32 word after rounding. An overflow or an infinity gives 0x7F80 or 0xFF80, and a NaN gives 0x7FC0.
- R9: A value below the target's smallest normal becomes a subnormal code. A value at or below half of the smallest subnormal (a tie rounds to even) becomes signed zero. FP32 subnormal inputs are converted by the same rules.
- R10: Widening is exact. It takes the code from the low bits of `in_data` and ignores the bits above the code. NaN codes give 0x7FC00000, and infinities keep their sign. Widening the 16-bit format appends sixteen zero bits, so a NaN payload is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 32 | FP32 word, or a narrow code in the low bits for widening |
| in_mode | input | 3 | Target encoding and direction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Narrow code, zero-extended, or FP32 word |

## Verification
A wrong re-bias or rounding decision shows at the ports as an off-by-one code two cycles after the operand is accepted. The test vectors therefore sit on exact rounding ties, on the saturation boundary and on the subnormal edge of every format. A broken stall path shows the same cycle the consumer drops ready, as a changing output or a ready that stays high. A valid bit lost between the stages shows as a missing or reordered result in the streamed table.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   typedef enum logic [2:0] {
      LPF_TO_BF16   = 3'd0,
      LPF_TO_E4M3   = 3'd1,
      LPF_TO_E5M2   = 3'd2,
      LPF_TO_E2M1   = 3'd3,
      LPF_FROM_BF16 = 3'd4,
      LPF_FROM_E4M3 = 3'd5,
      LPF_FROM_E5M2 = 3'd6,
      LPF_FROM_E2M1 = 3'd7
   } lpf_mode_e;

   // Special-value conventions of a narrow lane
   localparam int STYLE_IEEE   = 0;  // all-ones exponent: infinity and NaN
   localparam int STYLE_TOPNAN = 1;  // only the all-ones code is NaN, no infinity
   localparam int STYLE_NOSPEC = 2;  // every code is finite

   localparam int LPF_LANES  = 4;
   localparam int SRC_MAN_W  = 23;
   localparam int SRC_BIAS   = 127;
   localparam int CODE_W     = 16;
   localparam logic [31:0] FP32_QNAN = 32'h7FC0_0000;

   typedef struct packed {
      logic               sign;
      logic               special;  // exponent all ones
      logic               nan;
      logic signed [9:0]  exp_unb;  // unbiased exponent
      logic [23:0]        sig;      // significand with hidden bit
   } lpf_unpacked_t;

   function automatic int lane_ew(input int i);
      case (i)
         0:       return 8;
         1:       return 4;
         2:       return 5;
         default: return 2;
      endcase
   endfunction

   function automatic int lane_mw(input int i);
      case (i)
         0:       return 7;
         1:       return 3;
         2:       return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int lane_style(input int i);
      case (i)
         1:       return STYLE_TOPNAN;
         3:       return STYLE_NOSPEC;
         default: return STYLE_IEEE;
      endcase
   endfunction

endpackage

// File: rtl/lpf_unpack.sv
module lpf_unpack
   import lpf_pkg::*;
(
   input  logic [31:0]   word,
   output lpf_unpacked_t u
);
   logic [7:0]  ex;
   logic [22:0] fr;

   always_comb begin
      ex        = word[30:23];
      fr        = word[22:0];
      u.sign    = word[31];
      u.special = &ex;
      u.nan     = (&ex) && (|fr);
      u.sig     = {|ex, fr};
      if (ex == 8'd0) u.exp_unb = -10'sd126;
      else            u.exp_unb = $signed({2'b00, ex}) - 10'sd127;
   end
endmodule

// File: rtl/lpf_narrow.sv
module lpf_narrow
   import lpf_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 3,
   parameter int STYLE = STYLE_TOPNAN
) (
   input  lpf_unpacked_t     u,
   output logic [CODE_W-1:0] code
);
   localparam int MAG_W    = EXP_W + MAN_W;
   localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
   localparam int EALL     = (1 << EXP_W) - 1;
   localparam int INF_CODE = EALL << MAN_W;
   localparam int MAX_CODE = (STYLE == STYLE_IEEE)   ? (((EALL - 1) << MAN_W) | ((1 << MAN_W) - 1)) :
                             (STYLE == STYLE_TOPNAN) ? ((1 << MAG_W) - 2) : ((1 << MAG_W) - 1);
   localparam int NAN_CODE = (STYLE == STYLE_IEEE)   ? (INF_CODE | (1 << (MAN_W - 1))) :
                             (STYLE == STYLE_TOPNAN) ? ((1 << MAG_W) - 1) : MAX_CODE;
   localparam int OVF_CODE = (STYLE == STYLE_IEEE) ? INF_CODE : MAX_CODE;
   localparam logic signed [11:0] SH_NORM = 12'(SRC_MAN_W - MAN_W);

   if (MAN_W < 1 || MAN_W > 7 || EXP_W < 2 || EXP_W > 8 || MAG_W + 1 > CODE_W) begin : g_bad_geom
      $error("lpf_narrow: unsupported lane geometry");
   end
   if (STYLE < STYLE_IEEE || STYLE > STYLE_NOSPEC) begin : g_bad_style
      $error("lpf_narrow: unknown special-value style");
   end

   logic signed [11:0] te;
   logic signed [11:0] sh_wide;
   logic [4:0]         sh;
   logic [31:0]        sig32, kept, rem, half, q, base, mag, mag_f;
   logic               rnd, sgn;

   always_comb begin
      te      = {{2{u.exp_unb[9]}}, u.exp_unb} + 12'(BIAS);
      if (te >= 12'sd1) begin
         base    = 32'(te - 12'sd1);
         sh_wide = SH_NORM;
      end else begin
         base    = 32'd0;
         sh_wide = SH_NORM + 12'sd1 - te;
      end
      sh    = (sh_wide > 12'sd31) ? 5'd31 : sh_wide[4:0];
      sig32 = {8'h00, u.sig};
      kept  = sig32 >> sh;
      rem   = sig32 & ((32'd1 << sh) - 32'd1);
      half  = 32'd1 << (sh - 5'd1);
      rnd   = (rem > half) || ((rem == half) && kept[0]);
      q     = kept + {31'd0, rnd};
      mag   = (base << MAN_W) + q;
      sgn   = u.sign;
      if (u.nan) begin
         mag_f = 32'(NAN_CODE);
         sgn   = 1'b0;
      end else if (u.special || (mag > 32'(MAX_CODE))) begin
         mag_f = 32'(OVF_CODE);
      end else begin
         mag_f = mag;
      end
      code              = '0;
      code[MAG_W]       = sgn;
      code[MAG_W-1:0]   = mag_f[MAG_W-1:0];
   end
endmodule

// File: rtl/lpf_widen.sv
module lpf_widen
   import lpf_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 3,
   parameter int STYLE = STYLE_TOPNAN
) (
   input  logic [CODE_W-1:0] code,
   output logic [31:0]       word
);
   localparam int MAG_W = EXP_W + MAN_W;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

   if (EXP_W == 8) begin : g_pass
      if (MAN_W != 7) begin : g_bad_pass
         $error("lpf_widen: full-exponent lane must be 16 bits wide");
      end
      assign word = {code, 16'h0000};
   end else begin : g_gen
      if (EXP_W > 6 || MAN_W < 1 || MAG_W + 1 > CODE_W) begin : g_bad_geom
         $error("lpf_widen: unsupported lane geometry");
      end

      logic               s, is_nan, is_inf;
      logic [EXP_W-1:0]   e;
      logic [MAN_W-1:0]   m, m_clr;
      logic [7:0]         ex;
      logic [22:0]        fr;
      int                 p;
      logic               unused_hi;

      assign unused_hi = ^code[CODE_W-1:MAG_W+1];

      always_comb begin
         s  = code[MAG_W];
         e  = code[MAG_W-1:MAN_W];
         m  = code[MAN_W-1:0];
         p  = 0;
         for (int i = 0; i < MAN_W; i++) begin
            if (m[i]) p = i;
         end
         m_clr = m & ~(MAN_W'(1) << p);
         if (STYLE == STYLE_IEEE) begin
            is_nan = (&e) && (|m);
            is_inf = (&e) && !(|m);
         end else if (STYLE == STYLE_TOPNAN) begin
            is_nan = (&e) && (&m);
            is_inf = 1'b0;
         end else begin
            is_nan = 1'b0;
            is_inf = 1'b0;
         end
         ex = 8'd0;
         fr = 23'd0;
         if (is_nan) begin
            word = FP32_QNAN;
         end else if (is_inf) begin
            word = {s, 8'hFF, 23'd0};
         end else if (e != '0) begin
            ex   = 8'(int'(e) - BIAS + SRC_BIAS);
            fr   = 23'(m) << (SRC_MAN_W - MAN_W);
            word = {s, ex, fr};
         end else if (m != '0) begin
            ex   = 8'(SRC_BIAS + 1 - BIAS - (MAN_W - p));
            fr   = 23'(m_clr) << (SRC_MAN_W - p);
            word = {s, ex, fr};
         end else begin
            word = {s, 31'd0};
         end
      end
   end
endmodule

// File: rtl/lpf_convert.sv
module lpf_convert
   import lpf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [31:0] in_data,
   input  logic [2:0]  in_mode,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [31:0] out_data
);
   localparam int LANE_SEL_W = $clog2(LPF_LANES);

   if (LPF_LANES != 4) begin : g_bad_lanes
      $error("lpf_convert: mode decode assumes four lanes");
   end

   // Stage 1: decoded operand
   logic              s1_valid;
   lpf_unpacked_t     s1_u;
   logic [CODE_W-1:0] s1_raw;
   lpf_mode_e         s1_mode;
   lpf_unpacked_t     dec_u;
   logic              adv;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   lpf_unpack u_unpack (.word(in_data), .u(dec_u));

   // Stage 2 combinational lanes
   logic [CODE_W-1:0] n_code [LPF_LANES];
   logic [31:0]       w_word [LPF_LANES];
   logic [31:0]       result;
   logic [LANE_SEL_W-1:0] lane;

   for (genvar g = 0; g < LPF_LANES; g++) begin : g_lane
      lpf_narrow #(
         .EXP_W(lane_ew(g)), .MAN_W(lane_mw(g)), .STYLE(lane_style(g))
      ) u_narrow (.u(s1_u), .code(n_code[g]));
      lpf_widen #(
         .EXP_W(lane_ew(g)), .MAN_W(lane_mw(g)), .STYLE(lane_style(g))
      ) u_widen (.code(s1_raw), .word(w_word[g]));
   end

   always_comb begin
      lane   = s1_mode[LANE_SEL_W-1:0];
      result = s1_mode[2] ? w_word[lane] : {16'h0000, n_code[lane]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_u      <= '0;
         s1_raw    <= '0;
         s1_mode   <= LPF_TO_BF16;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (adv) begin
         s1_valid  <= in_valid;
         out_valid <= s1_valid;
         if (in_valid) begin
            s1_u    <= dec_u;
            s1_raw  <= in_data[CODE_W-1:0];
            s1_mode <= lpf_mode_e'(in_mode);
         end
         if (s1_valid) out_data <= result;
      end
   end

   // R1: a stalled result holds
   a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R2: valid moves one stage per accepting edge
   a_r2_stage1_fill: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> s1_valid);
   a_r2_stage2_fill: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && in_ready |=> out_valid);

   // R3: narrow results leave the upper half clear
   a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && in_ready && !s1_mode[2] |=> out_data[31:16] == 16'h0000);

   // R5: only a NaN input yields the 4/3 NaN code
   a_r5_e4m3_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && in_ready && (s1_mode == LPF_TO_E4M3) && !s1_u.nan |=> out_data[6:0] != 7'h7F);

   // R6: only a NaN input yields a 5/2 NaN code
   a_r6_e5m2_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && in_ready && (s1_mode == LPF_TO_E5M2) && !s1_u.nan
      |=> !((out_data[6:2] == 5'h1F) && (out_data[1:0] != 2'b00)));
endmodule

// File: tb/lpf_convert_test.sv
`timescale 1ns/1ps
module lpf_convert_test;
   typedef struct packed {
      logic [7:0]  req;
      logic [2:0]  mode;
      logic [31:0] din;
      logic [31:0] dout;
   } vec_t;

   localparam int NV = 65;
   localparam vec_t VECS [NV] = '{
      '{8'd8, 3'd0, 32'h3F800000, 32'h00003F80},  // R8
      '{8'd4, 3'd0, 32'h3F808000, 32'h00003F80},  // R4 tie, even kept
      '{8'd4, 3'd0, 32'h3F818000, 32'h00003F82},  // R4 tie, odd rounds up
      '{8'd4, 3'd0, 32'h3F808001, 32'h00003F81},  // R4 above half
      '{8'd8, 3'd0, 32'h7F7FFFFF, 32'h00007F80},  // R8 overflow
      '{8'd8, 3'd0, 32'hFF800000, 32'h0000FF80},  // R8
      '{8'd8, 3'd0, 32'h7FC00001, 32'h00007FC0},  // R8
      '{8'd8, 3'd0, 32'hFF800001, 32'h00007FC0},  // R8
      '{8'd9, 3'd0, 32'h00010000, 32'h00000001},  // R9
      '{8'd9, 3'd0, 32'h80008000, 32'h00008000},  // R9
      '{8'd8, 3'd0, 32'hC0490FDB, 32'h0000C049},  // R8
      '{8'd5, 3'd1, 32'h3F800000, 32'h00000038},  // R5
      '{8'd5, 3'd1, 32'h43E00000, 32'h0000007E},  // R5
      '{8'd5, 3'd1, 32'h43F00000, 32'h0000007E},  // R5
      '{8'd5, 3'd1, 32'hC9742400, 32'h000000FE},  // R5
      '{8'd5, 3'd1, 32'h7F800000, 32'h0000007E},  // R5
      '{8'd5, 3'd1, 32'hFF800000, 32'h000000FE},  // R5
      '{8'd5, 3'd1, 32'h7FC00000, 32'h0000007F},  // R5
      '{8'd9, 3'd1, 32'h3C800000, 32'h00000008},  // R9
      '{8'd9, 3'd1, 32'h3B000000, 32'h00000001},  // R9
      '{8'd9, 3'd1, 32'h3A800000, 32'h00000000},  // R9
      '{8'd9, 3'd1, 32'hBA800000, 32'h00000080},  // R9
      '{8'd9, 3'd1, 32'h3A800001, 32'h00000001},  // R9
      '{8'd4, 3'd1, 32'h3F880000, 32'h00000038},  // R4
      '{8'd4, 3'd1, 32'h3F980000, 32'h0000003A},  // R4
      '{8'd9, 3'd1, 32'h80000000, 32'h00000080},  // R9
      '{8'd9, 3'd1, 32'h00000001, 32'h00000000},  // R9
      '{8'd6, 3'd2, 32'h3F800000, 32'h0000003C},  // R6
      '{8'd6, 3'd2, 32'h47600000, 32'h0000007B},  // R6
      '{8'd6, 3'd2, 32'h47700000, 32'h0000007C},  // R6
      '{8'd6, 3'd2, 32'hFF800000, 32'h000000FC},  // R6
      '{8'd6, 3'd2, 32'hFFC00000, 32'h0000007E},  // R6
      '{8'd9, 3'd2, 32'h37800000, 32'h00000001},  // R9
      '{8'd9, 3'd2, 32'hB7000000, 32'h00000080},  // R9
      '{8'd6, 3'd2, 32'h3FC00000, 32'h0000003E},  // R6
      '{8'd6, 3'd2, 32'hBFA00000, 32'h000000BD},  // R6
      '{8'd7, 3'd3, 32'h3F800000, 32'h00000002},  // R7
      '{8'd7, 3'd3, 32'h40C00000, 32'h00000007},  // R7
      '{8'd4, 3'd3, 32'h40A00000, 32'h00000006},  // R4
      '{8'd7, 3'd3, 32'h40E00000, 32'h00000007},  // R7
      '{8'd7, 3'd3, 32'hC2C80000, 32'h0000000F},  // R7
      '{8'd7, 3'd3, 32'h7FC00000, 32'h00000007},  // R7
      '{8'd7, 3'd3, 32'hFF800000, 32'h0000000F},  // R7
      '{8'd4, 3'd3, 32'h3E800000, 32'h00000000},  // R4
      '{8'd4, 3'd3, 32'h3F400000, 32'h00000002},  // R4
      '{8'd9, 3'd3, 32'h3F000000, 32'h00000001},  // R9
      '{8'd7, 3'd3, 32'h40400000, 32'h00000005},  // R7
      '{8'd9, 3'd3, 32'hBE000000, 32'h00000008},  // R9
      '{8'd10, 3'd4, 32'h00003F80, 32'h3F800000}, // R10
      '{8'd10, 3'd4, 32'h0000FF81, 32'hFF810000}, // R10
      '{8'd10, 3'd5, 32'h00000038, 32'h3F800000}, // R10
      '{8'd10, 3'd5, 32'h0000007E, 32'h43E00000}, // R10
      '{8'd10, 3'd5, 32'h000000FF, 32'h7FC00000}, // R10
      '{8'd10, 3'd5, 32'h00000001, 32'h3B000000}, // R10
      '{8'd10, 3'd5, 32'h00000006, 32'h3C400000}, // R10
      '{8'd10, 3'd5, 32'h0000AB38, 32'h3F800000}, // R10 upper bits ignored
      '{8'd10, 3'd6, 32'h0000007C, 32'h7F800000}, // R10
      '{8'd10, 3'd6, 32'h000000FC, 32'hFF800000}, // R10
      '{8'd10, 3'd6, 32'h0000007D, 32'h7FC00000}, // R10
      '{8'd10, 3'd6, 32'h0000007B, 32'h47600000}, // R10
      '{8'd10, 3'd6, 32'h00000001, 32'h37800000}, // R10
      '{8'd10, 3'd7, 32'h00000007, 32'h40C00000}, // R10
      '{8'd10, 3'd7, 32'h00000001, 32'h3F000000}, // R10
      '{8'd10, 3'd7, 32'h0000000B, 32'hBFC00000}, // R10
      '{8'd10, 3'd7, 32'h00000008, 32'h80000000}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [31:0] in_data;
   logic [2:0]  in_mode;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_data;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   lpf_convert uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_mode(in_mode),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_data   = '0;
      in_mode   = '0;
      out_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state: R1, R2
      chk(2, {31'd0, out_valid}, 32'd0);
      chk(1, {31'd0, in_ready}, 32'd1);

      // Streamed table, one operand per cycle: R2 ordering and throughput
      fork
         begin
            for (int i = 0; i < NV; i++) begin
               in_valid = 1'b1;
               in_data  = VECS[i].din;
               in_mode  = VECS[i].mode;
               @(negedge clk);
            end
            in_valid = 1'b0;
         end
         begin
            int k = 0;
            int idle = 0;
            while (k < NV && idle < 10) begin
               @(negedge clk);
               if (out_valid) begin
                  chk(int'(VECS[k].req), out_data, VECS[k].dout);
                  k++;
                  idle = 0;
               end else if (k > 0) begin
                  idle++;
               end
            end
            chk(2, 32'(k), 32'(NV));  // R2: every result emitted
         end
      join
      repeat (3) @(negedge clk);

      // Latency: R2
      in_valid = 1'b1; in_mode = 3'd1; in_data = 32'h43E00000;
      @(negedge clk);
      in_valid = 1'b0;
      chk(2, {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      chk(2, {31'd0, out_valid}, 32'd1);
      chk(2, out_data, 32'h0000007E);
      @(negedge clk);
      chk(2, {31'd0, out_valid}, 32'd0);

      // Stall: R1
      out_ready = 1'b0;
      in_valid = 1'b1; in_mode = 3'd1; in_data = 32'h3F800000;
      @(negedge clk);
      in_mode = 3'd2; in_data = 32'h3F800000;
      @(negedge clk);
      in_valid = 1'b0;
      chk(1, {31'd0, out_valid}, 32'd1);
      chk(1, out_data, 32'h00000038);
      chk(1, {31'd0, in_ready}, 32'd0);
      repeat (3) @(negedge clk);
      chk(1, {31'd0, out_valid}, 32'd1);
      chk(1, out_data, 32'h00000038);
      chk(1, {31'd0, in_ready}, 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      chk(1, {31'd0, out_valid}, 32'd1);
      chk(1, out_data, 32'h0000003C);
      @(negedge clk);
      chk(1, {31'd0, out_valid}, 32'd0);

      // Reset mid-flight clears the pipe: R2
      in_valid = 1'b1; in_mode = 3'd0; in_data = 32'h3F800000;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(2, {31'd0, out_valid}, 32'd0);

      finish_run();
   end
endmodule